// File: doc/BRIEF.md
# Flip-on-Write Bit-Array Similarity Evaluator

This block holds a reference binary image as a two-dimensional bit array and compares a second image against it in place. A load writes one row of reference bits verbatim. A compare write then applies one row of the second image as a toggle mask: every stored bit whose incoming bit is 1 is inverted, and every other bit is kept. After both images have passed through, each stored bit is 1 exactly where the two images differ.

The array is split into `NGRP` row groups of `G` rows each. An evaluate command names a group and a column. In group mode the G bits of that column slice are counted at once, and a single mismatch flag is returned one cycle later. The flag is 1 when the count is above a programmable threshold. In exact mode the slice is read one bit per cycle and the final mismatch count is reported with a done strobe, at the cost of G extra cycles. The similarity ratio is (G minus the count) divided by G. With G = 10 and a threshold of 3, a flag of 1 means at most 60% similarity and a flag of 0 means at least 70%.

A small controller runs three states. `ST_IDLE` waits for commands. `ST_SCAN` steps through the slice one bit per cycle. `ST_DONE` presents the final count for one cycle. The transitions are:
- `ST_IDLE` to `ST_SCAN` on an accepted exact evaluate.
- `ST_SCAN` to `ST_DONE` after the G-th bit.
- `ST_DONE` to `ST_SCAN` on another accepted exact evaluate, and to `ST_IDLE` otherwise.

Top module: `bitgrid_match_eval`

## Requirements
- R1: A load with `ld_en` high stores `ld_bits` verbatim into row `ld_row`. Bit c of the row sits in column c.
- R2: A compare write with `cw_en` high replaces row `cw_row` with its old content XOR `cw_bits`. A 1 in `cw_bits` toggles that bit whatever its value, and a 0 leaves it. Applying the same word twice restores the row.
- R3: A group evaluate (`ev_en` high, `ev_exact` low) on group g and column c raises `flag_vld_o` for one cycle, on the cycle after the command. At the same time `flag_o` becomes 1 if the number of ones in column c of rows g*G to g*G+G-1 exceeds the threshold, and 0 otherwise. `flag_o` holds its value until the next group evaluate.
- R4: `thr_we` loads `thr_val` into the threshold register. An evaluate issued in the same cycle as a threshold write still uses the previous threshold. Later evaluates use the new one.
- R5: An exact evaluate (`ev_en` and `ev_exact` high) does not raise `flag_vld_o`. `done_o` is high for exactly one cycle, G+1 cycles after the command. At that point `count_o` equals the number of ones in the addressed slice, and `count_o` holds that value after `done_o` falls.
- R6: If two or more of `ld_en`, `cw_en` and `ev_en` are high in one cycle, none of the three commands takes effect, and `busy_o` is high on the next cycle only.
- R7: While an exact scan is in progress, any load, compare write or evaluate is ignored, `busy_o` is high on the next cycle, and the count being built is unaffected.
- R8: Reset clears the whole array and sets every output to 0. It sets the threshold to G/2, rounded down.
- R9: With G = 10 and a threshold of 3, a slice with 4 ones yields flag 1 (at most 60% similar) and a slice with 3 ones yields flag 0 (at least 70% similar).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load the reference row |
| ld_row | input | RW | Row addressed by a load |
| ld_bits | input | COLS | Reference bits to store |
| cw_en | input | 1 | Compare write (toggle mask) |
| cw_row | input | RW | Row addressed by a compare write |
| cw_bits | input | COLS | Comparison bits; 1 toggles the stored bit |
| thr_we | input | 1 | Threshold register write |
| thr_val | input | CW | New threshold value |
| ev_en | input | 1 | Evaluate command |
| ev_exact | input | 1 | 1 selects the exact bit-by-bit count, 0 the group flag |
| ev_grp | input | GAW | Row group to evaluate |
| ev_col | input | CAW | Column to evaluate |
| busy_o | output | 1 | The previous cycle's command was rejected |
| flag_vld_o | output | 1 | One-cycle strobe for a new group flag |
| flag_o | output | 1 | Mismatch flag of the last group evaluate |
| done_o | output | 1 | One-cycle strobe at the end of an exact scan |
| count_o | output | CW | Mismatch count of the last exact scan |

## Verification
The bench builds two instances. The first uses G = 10, four groups and eight columns. Its slice counts come out as (c + 8g) mod 11, so every count from 0 to 10 occurs, and the 60%/70% boundary at threshold 3 can be checked directly. The second uses G = 16, two groups and nine columns, which reaches every count from 0 to 16 and a 5-bit count width. On both instances, every threshold from 0 to G is swept across every slice. Every slice is also scanned in exact mode.

// File: rtl/bgm_pkg.sv
`timescale 1ns/1ps
package bgm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } bgm_state_e;

    // bits needed to index n items (at least one)
    function automatic int idx_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bgm_store.sv
`timescale 1ns/1ps
module bgm_store import bgm_pkg::*; #(
    parameter int G    = 10,
    parameter int NGRP = 4,
    parameter int COLS = 8,
    localparam int ROWS = G * NGRP,
    localparam int RW   = idx_w(ROWS),
    localparam int GAW  = idx_w(NGRP),
    localparam int CAW  = idx_w(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_ok,
    input  logic [RW-1:0]   ld_row,
    input  logic [COLS-1:0] ld_bits,
    input  logic            cw_ok,
    input  logic [RW-1:0]   cw_row,
    input  logic [COLS-1:0] cw_bits,
    input  logic [GAW-1:0]  rd_grp,
    input  logic [CAW-1:0]  rd_col,
    output logic [G-1:0]    grp_bits
);

    logic [COLS-1:0] mem [ROWS];

    // load writes verbatim; compare write toggles where the mask is 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem[r] <= '0;
            end
        end else begin
            if (ld_ok && (int'(ld_row) < ROWS)) begin
                mem[ld_row] <= ld_bits;
            end
            if (cw_ok && (int'(cw_row) < ROWS)) begin
                mem[cw_row] <= mem[cw_row] ^ cw_bits;
            end
        end
    end

    // column slice of the addressed row group
    always_comb begin
        int rr;
        for (int i = 0; i < G; i++) begin
            rr = int'(rd_grp) * G + i;
            if (rr < ROWS && int'(rd_col) < COLS) begin
                grp_bits[i] = mem[rr[RW-1:0]][rd_col];
            end else begin
                grp_bits[i] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/bgm_popcnt.sv
`timescale 1ns/1ps
module bgm_popcnt #(
    parameter int G  = 10,
    parameter int CW = 4
) (
    input  logic [G-1:0]  bits,
    output logic [CW-1:0] ones
);

    logic [CW-1:0] part [G+1];

    assign part[0] = '0;

    for (genvar i = 0; i < G; i++) begin : g_acc
        assign part[i+1] = part[i] + CW'(bits[i]);
    end

    assign ones = part[G];

endmodule

// File: rtl/bgm_ctrl.sv
`timescale 1ns/1ps
module bgm_ctrl import bgm_pkg::*; #(
    parameter int G   = 10,
    parameter int GAW = 2,
    parameter int CAW = 3,
    parameter int CW  = 4,
    localparam int IW = idx_w(G)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_en,
    input  logic           cw_en,
    input  logic           ev_en,
    input  logic           ev_exact,
    input  logic [GAW-1:0] ev_grp,
    input  logic [CAW-1:0] ev_col,
    input  logic           thr_we,
    input  logic [CW-1:0]  thr_val,
    input  logic [G-1:0]   grp_bits,
    input  logic [CW-1:0]  grp_cnt,
    output logic           ld_ok,
    output logic           cw_ok,
    output logic [GAW-1:0] rd_grp,
    output logic [CAW-1:0] rd_col,
    output logic           scan_o,
    output logic           busy_o,
    output logic           flag_vld_o,
    output logic           flag_o,
    output logic           done_o,
    output logic [CW-1:0]  count_o
);

    bgm_state_e     state, nxt;
    logic [IW-1:0]  idx_q;
    logic [GAW-1:0] sg_q;
    logic [CAW-1:0] sc_q;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  thr_q;
    logic           flag_q, vld_q, busy_q;
    logic           multi, scanning, clash, ev_ok, last;

    always_comb begin
        multi    = (ld_en && cw_en) || (ld_en && ev_en) || (cw_en && ev_en);
        scanning = (state == ST_SCAN);
        clash    = multi || (scanning && (ld_en || cw_en || ev_en));
        ld_ok    = ld_en && !clash;
        cw_ok    = cw_en && !clash;
        ev_ok    = ev_en && !clash;
        last     = (idx_q == IW'(G - 1));
        rd_grp   = scanning ? sg_q : ev_grp;
        rd_col   = scanning ? sc_q : ev_col;
    end

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (ev_ok && ev_exact) nxt = ST_SCAN;
            ST_SCAN: if (last) nxt = ST_DONE;
            ST_DONE: nxt = (ev_ok && ev_exact) ? ST_SCAN : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // scan datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            sg_q   <= '0;
            sc_q   <= '0;
            cnt_q  <= '0;
            thr_q  <= CW'(G / 2);
            flag_q <= 1'b0;
            vld_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            busy_q <= clash;
            vld_q  <= ev_ok && !ev_exact;
            if (thr_we) begin
                thr_q <= thr_val;
            end
            if (ev_ok && !ev_exact) begin
                flag_q <= (grp_cnt > thr_q);
            end
            if (ev_ok && ev_exact) begin
                idx_q <= '0;
                cnt_q <= '0;
                sg_q  <= ev_grp;
                sc_q  <= ev_col;
            end else if (scanning) begin
                cnt_q <= cnt_q + CW'(grp_bits[idx_q]);
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign scan_o     = scanning;
    assign busy_o     = busy_q;
    assign flag_vld_o = vld_q;
    assign flag_o     = flag_q;
    assign done_o     = (state == ST_DONE);
    assign count_o    = cnt_q;

endmodule

// File: rtl/bitgrid_match_eval.sv
`timescale 1ns/1ps
module bitgrid_match_eval import bgm_pkg::*; #(
    parameter int G    = 10,
    parameter int NGRP = 4,
    parameter int COLS = 8,
    localparam int ROWS = G * NGRP,
    localparam int RW   = idx_w(ROWS),
    localparam int GAW  = idx_w(NGRP),
    localparam int CAW  = idx_w(COLS),
    localparam int CW   = $clog2(G + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic [RW-1:0]   ld_row,
    input  logic [COLS-1:0] ld_bits,
    input  logic            cw_en,
    input  logic [RW-1:0]   cw_row,
    input  logic [COLS-1:0] cw_bits,
    input  logic            thr_we,
    input  logic [CW-1:0]   thr_val,
    input  logic            ev_en,
    input  logic            ev_exact,
    input  logic [GAW-1:0]  ev_grp,
    input  logic [CAW-1:0]  ev_col,
    output logic            busy_o,
    output logic            flag_vld_o,
    output logic            flag_o,
    output logic            done_o,
    output logic [CW-1:0]   count_o
);

    logic           ld_ok, cw_ok, scan_w;
    logic [GAW-1:0] rd_grp;
    logic [CAW-1:0] rd_col;
    logic [G-1:0]   slice;
    logic [CW-1:0]  slice_ones;

    bgm_store #(.G(G), .NGRP(NGRP), .COLS(COLS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_ok    (ld_ok),
        .ld_row   (ld_row),
        .ld_bits  (ld_bits),
        .cw_ok    (cw_ok),
        .cw_row   (cw_row),
        .cw_bits  (cw_bits),
        .rd_grp   (rd_grp),
        .rd_col   (rd_col),
        .grp_bits (slice)
    );

    bgm_popcnt #(.G(G), .CW(CW)) u_popcnt (
        .bits (slice),
        .ones (slice_ones)
    );

    bgm_ctrl #(.G(G), .GAW(GAW), .CAW(CAW), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (ld_en),
        .cw_en      (cw_en),
        .ev_en      (ev_en),
        .ev_exact   (ev_exact),
        .ev_grp     (ev_grp),
        .ev_col     (ev_col),
        .thr_we     (thr_we),
        .thr_val    (thr_val),
        .grp_bits   (slice),
        .grp_cnt    (slice_ones),
        .ld_ok      (ld_ok),
        .cw_ok      (cw_ok),
        .rd_grp     (rd_grp),
        .rd_col     (rd_col),
        .scan_o     (scan_w),
        .busy_o     (busy_o),
        .flag_vld_o (flag_vld_o),
        .flag_o     (flag_o),
        .done_o     (done_o),
        .count_o    (count_o)
    );

endmodule

// File: rtl/bgm_checks.sv
`timescale 1ns/1ps
module bgm_checks #(
    parameter int G  = 10,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld_en,
    input logic          cw_en,
    input logic          ev_en,
    input logic          ev_exact,
    input logic          scan,
    input logic          busy_o,
    input logic          flag_vld_o,
    input logic          done_o,
    input logic [CW-1:0] count_o
);

    logic [CW:0] scan_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_len <= '0;
        end else if (scan) begin
            scan_len <= scan_len + 1'b1;
        end else begin
            scan_len <= '0;
        end
    end

    a_r6_clash_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({ld_en, cw_en, ev_en}) > 1) |=> busy_o);

    a_r6_clash_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({ld_en, cw_en, ev_en}) > 1) |=> !flag_vld_o);

    a_r7_scan_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && (ld_en || cw_en || ev_en)) |=> busy_o);

    a_r3_flag_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_en && !ev_exact && !ld_en && !cw_en && !scan) |=> flag_vld_o);

    a_r5_exact_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_en && ev_exact) |=> !flag_vld_o);

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (count_o <= CW'(G)));

    a_r5_scan_length: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (scan_len == (CW+1)'(G)));

endmodule

bind bitgrid_match_eval bgm_checks #(.G(G), .CW(CW)) u_bgm_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_en),
    .cw_en      (cw_en),
    .ev_en      (ev_en),
    .ev_exact   (ev_exact),
    .scan       (scan_w),
    .busy_o     (busy_o),
    .flag_vld_o (flag_vld_o),
    .done_o     (done_o),
    .count_o    (count_o)
);

// File: tb/bgm_bench_core.sv
`timescale 1ns/1ps
module bgm_bench_core import bgm_pkg::*; #(
    parameter int G    = 10,
    parameter int NGRP = 4,
    parameter int COLS = 8
) (
    input  logic clk,
    output int   n_chk,
    output int   n_err,
    output logic fin
);

    localparam int ROWS = G * NGRP;
    localparam int RW   = idx_w(ROWS);
    localparam int GAW  = idx_w(NGRP);
    localparam int CAW  = idx_w(COLS);
    localparam int CW   = $clog2(G + 1);

    logic            rst_n;
    logic            ld_en, cw_en, thr_we, ev_en, ev_exact;
    logic [RW-1:0]   ld_row, cw_row;
    logic [COLS-1:0] ld_bits, cw_bits;
    logic [CW-1:0]   thr_val;
    logic [GAW-1:0]  ev_grp;
    logic [CAW-1:0]  ev_col;
    logic            busy_o, flag_vld_o, flag_o, done_o;
    logic [CW-1:0]   count_o;

    logic [COLS-1:0] mref [ROWS];
    int              thr_m;

    bitgrid_match_eval #(.G(G), .NGRP(NGRP), .COLS(COLS)) u_bitgrid_match_eval (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_row(ld_row), .ld_bits(ld_bits),
        .cw_en(cw_en), .cw_row(cw_row), .cw_bits(cw_bits),
        .thr_we(thr_we), .thr_val(thr_val),
        .ev_en(ev_en), .ev_exact(ev_exact), .ev_grp(ev_grp), .ev_col(ev_col),
        .busy_o(busy_o), .flag_vld_o(flag_vld_o), .flag_o(flag_o),
        .done_o(done_o), .count_o(count_o)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s (G=%0d) actual=%0d expected=%0d", tag, G, act, exp);
        end
    endtask

    task automatic idle();
        ld_en = 0; cw_en = 0; thr_we = 0; ev_en = 0; ev_exact = 0;
        ld_row = '0; cw_row = '0; ld_bits = '0; cw_bits = '0;
        thr_val = '0; ev_grp = '0; ev_col = '0;
    endtask

    function automatic logic [COLS-1:0] pat_a(input int r);
        logic [COLS-1:0] v;
        for (int c = 0; c < COLS; c++) v[c] = ((r * 7 + c * 3) % 5) < 2;
        return v;
    endfunction

    // intended mismatch pattern: slice (g,c) gets (c + COLS*g) mod (G+1) ones
    function automatic logic [COLS-1:0] pat_d(input int r);
        logic [COLS-1:0] v;
        for (int c = 0; c < COLS; c++) v[c] = (r % G) < ((c + COLS * (r / G)) % (G + 1));
        return v;
    endfunction

    function automatic int exp_cnt(input int g, input int c);
        int n = 0;
        for (int i = 0; i < G; i++) n += int'(mref[g * G + i][c]);
        return n;
    endfunction

    task automatic do_load(input int r, input logic [COLS-1:0] v);
        ld_en = 1; ld_row = RW'(r); ld_bits = v;
        @(negedge clk);
        ld_en = 0;
        mref[r] = v;
    endtask

    task automatic do_cw(input int r, input logic [COLS-1:0] v);
        cw_en = 1; cw_row = RW'(r); cw_bits = v;
        @(negedge clk);
        cw_en = 0;
        mref[r] = mref[r] ^ v;
    endtask

    task automatic set_thr(input int t);
        thr_we = 1; thr_val = CW'(t);
        @(negedge clk);
        thr_we = 0;
        thr_m = t;
    endtask

    task automatic grp_eval(input int g, input int c, input string tag);
        int e;
        e = exp_cnt(g, c);
        ev_en = 1; ev_exact = 0; ev_grp = GAW'(g); ev_col = CAW'(c);
        @(negedge clk);
        ev_en = 0;
        chk(flag_vld_o == 1'b1, tag, int'(flag_vld_o), 1);
        chk(flag_o == (e > thr_m), tag, int'(flag_o), int'(e > thr_m));
    endtask

    task automatic exact_eval(input int g, input int c, input string tag);
        int e;
        e = exp_cnt(g, c);
        ev_en = 1; ev_exact = 1; ev_grp = GAW'(g); ev_col = CAW'(c);
        @(negedge clk);
        ev_en = 0; ev_exact = 0;
        chk(flag_vld_o == 1'b0, tag, int'(flag_vld_o), 0);
        repeat (G - 1) @(negedge clk);
        chk(done_o == 1'b0, tag, int'(done_o), 0);
        @(negedge clk);
        chk(done_o == 1'b1, tag, int'(done_o), 1);
        chk(int'(count_o) == e, tag, int'(count_o), e);
        @(negedge clk);
        chk(done_o == 1'b0, tag, int'(done_o), 0);
        chk(int'(count_o) == e, tag, int'(count_o), e);
    endtask

    initial begin
        n_chk = 0; n_err = 0; fin = 0; thr_m = G / 2;
        for (int r = 0; r < ROWS; r++) mref[r] = '0;
        rst_n = 0;
        idle();
        repeat (3) @(negedge clk);
        // R8: outputs after reset
        chk(busy_o == 0, "R8 busy", int'(busy_o), 0);
        chk(flag_vld_o == 0, "R8 flag_vld", int'(flag_vld_o), 0);
        chk(flag_o == 0, "R8 flag", int'(flag_o), 0);
        chk(done_o == 0, "R8 done", int'(done_o), 0);
        chk(count_o == 0, "R8 count", int'(count_o), 0);
        rst_n = 1;
        @(negedge clk);
        exact_eval(0, 0, "R8 cleared array");

        // R1: reference loads
        for (int r = 0; r < ROWS; r++) do_load(r, pat_a(r));
        exact_eval(0, 0, "R1 load");
        exact_eval(NGRP - 1, COLS - 1, "R1 load");

        // R2: compare writes leave XOR of the two images
        for (int r = 0; r < ROWS; r++) do_cw(r, pat_a(r) ^ pat_d(r));
        exact_eval(0, COLS - 1, "R2 xor");

        // R8: reset threshold G/2 still in force
        for (int g = 0; g < NGRP; g++)
            for (int c = 0; c < COLS; c++) grp_eval(g, c, "R8 reset threshold");

        // R3: every threshold over every slice
        for (int t = 0; t <= G; t++) begin
            set_thr(t);
            for (int g = 0; g < NGRP; g++)
                for (int c = 0; c < COLS; c++) grp_eval(g, c, "R3 group flag");
        end

        // R9: 60% / 70% boundary for a 10-bit group
        if (G == 10) begin
            set_thr(3);
            for (int g = 0; g < NGRP; g++)
                for (int c = 0; c < COLS; c++)
                    if (exp_cnt(g, c) == 3 || exp_cnt(g, c) == 4) grp_eval(g, c, "R9 boundary");
        end

        // R4: threshold written in the same cycle as an evaluate
        set_thr(0);
        thr_we = 1; thr_val = CW'(G);
        ev_en = 1; ev_exact = 0; ev_grp = '0; ev_col = CAW'(1);
        @(negedge clk);
        thr_we = 0; ev_en = 0;
        chk(flag_o == 1'b1, "R4 old threshold used", int'(flag_o), 1);
        thr_m = G;
        grp_eval(0, 1, "R4 new threshold");

        // R5: exact scan of every slice
        for (int g = 0; g < NGRP; g++)
            for (int c = 0; c < COLS; c++) exact_eval(g, c, "R5 exact count");

        // R2: toggle twice restores
        do_cw(0, '1);
        exact_eval(0, 0, "R2 toggle");
        do_cw(0, '1);
        exact_eval(0, 0, "R2 toggle back");

        // R6: evaluate together with compare write
        ev_en = 1; ev_exact = 0; ev_grp = '0; ev_col = '0;
        cw_en = 1; cw_row = '0; cw_bits = '1;
        @(negedge clk);
        ev_en = 0; cw_en = 0;
        chk(busy_o == 1'b1, "R6 busy", int'(busy_o), 1);
        chk(flag_vld_o == 1'b0, "R6 no flag", int'(flag_vld_o), 0);
        @(negedge clk);
        chk(busy_o == 1'b0, "R6 busy one cycle", int'(busy_o), 0);
        exact_eval(0, 0, "R6 array untouched");

        // R6: load together with compare write
        ld_en = 1; ld_row = RW'(1); ld_bits = '1;
        cw_en = 1; cw_row = '0; cw_bits = '1;
        @(negedge clk);
        ld_en = 0; cw_en = 0;
        chk(busy_o == 1'b1, "R6 busy", int'(busy_o), 1);
        exact_eval(0, 0, "R6 load dropped");
        exact_eval(0, 1, "R6 load dropped");

        // R7: compare write during a scan
        begin
            int e;
            e = exp_cnt(0, 1);
            ev_en = 1; ev_exact = 1; ev_grp = '0; ev_col = CAW'(1);
            @(negedge clk);
            ev_en = 0; ev_exact = 0;
            cw_en = 1; cw_row = '0; cw_bits = '1;
            @(negedge clk);
            cw_en = 0;
            chk(busy_o == 1'b1, "R7 busy during scan", int'(busy_o), 1);
            repeat (G - 1) @(negedge clk);
            chk(done_o == 1'b1, "R7 done", int'(done_o), 1);
            chk(int'(count_o) == e, "R7 count unaffected", int'(count_o), e);
            @(negedge clk);
        end
        exact_eval(0, 1, "R7 array untouched");

        fin = 1;
    end

endmodule

// File: tb/bitgrid_match_eval_bench.sv
`timescale 1ns/1ps
module bitgrid_match_eval_bench;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int   c10, e10, c16, e16;
    logic f10, f16;

    bgm_bench_core #(.G(10), .NGRP(4), .COLS(8)) u_core_g10 (
        .clk(clk), .n_chk(c10), .n_err(e10), .fin(f10)
    );

    bgm_bench_core #(.G(16), .NGRP(2), .COLS(9)) u_core_g16 (
        .clk(clk), .n_chk(c16), .n_err(e16), .fin(f16)
    );

    initial begin
        int n = 0;
        int wd = 0;
        @(posedge clk);
        while (!(f10 === 1'b1 && f16 === 1'b1) && n < 150000) begin
            @(posedge clk);
            n++;
        end
        if (!(f10 === 1'b1 && f16 === 1'b1)) begin
            wd = 1;
            $display("FAIL R5 watchdog: run incomplete actual=%0d expected=%0d", 0, 1);
        end
        $display("Simulation finished: %0d checks, %0d errors", c10 + c16 + wd, e10 + e16 + wd);
        $finish;
    end

endmodule